// File: doc/BRIEF.md
# Boot-Phase Address Redirect Decoder

This block is the first stage of address decoding on a 32-bit processor board. Reset puts it in a boot phase. While that phase lasts, every processor access to the lowest 16 MiB of the address space is steered to a boot memory. The boot memory is one of three: on-board flash, memory on the backplane bus, or a mezzanine card. Two static jumper inputs choose it. For backplane boots, the block also drives the VME address modifier that the backplane access needs: standard supervisor program space or standard supervisor data space, picked from the processor function code.

Software ends the boot phase with a write to a fixed exit address. After that write, the block raises an enable that hands the low range to a downstream programmable chip-select stage. That stage provides eight region selects. For every access, the block also pre-decodes which data bus serves it:

- the processor-side bus, in front of the bus sizer, or
- the I/O-side bus, behind the bus sizer.

All selects are combinational from the address inputs and are gated by the address strobe.

Top module: `boot_redirect_decoder`

## Requirements
- R1: While reset is held and in the first cycle after it, `cs_stage_en` is 0, and the boot phase is active.
- R2: With both jumper inputs at 0, a strobed boot-phase access to the low range asserts `sel_flash` only.
- R3: The source is chosen as follows. `jmp_vme`=1 selects the backplane (`sel_vme`), whatever `jmp_mezz` is. `jmp_vme`=0 with `jmp_mezz`=1 selects the mezzanine (`sel_mezz`).
- R4: The redirect covers addresses 0x0000_0000 through 0x00FF_FFFF inclusive. 0x0100_0000 and above never assert a boot select.
- R5: While `sel_vme` is 1, `vme_am` is 0x3E when `fc`=6 (supervisor program) and 0x3D for any other function code. While `sel_vme` is 0, `vme_am` is 0x00.
- R6: With `strobe`=0, every select output (`sel_flash`, `sel_vme`, `sel_mezz`, `cpu_bus_sel`, `io_bus_sel`) is 0.
- R7: A strobed write (`write`=1) to address 0xFFFF_FFF0 during the boot phase sets `cs_stage_en` to 1 from the next clock edge on. `cs_stage_en` stays 1 until reset. A read of that address does not end the boot phase.
- R8: Once `cs_stage_en` is 1, no boot select asserts for any address.
- R9: The jumpers are captured while reset is held. Changing them afterwards has no effect on the source until the next reset.
- R10: A strobed access with `fc`=7 (CPU space) asserts neither bus select. Any other strobed access asserts exactly one bus select. The bus select is `io_bus_sel` when `addr[31:28]`=0xF and `cpu_bus_sel` otherwise, except for boot-phase redirects (see R11).
- R11: At most one boot select is active at a time. A flash redirect uses `io_bus_sel`. A backplane or mezzanine redirect uses `cpu_bus_sel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 32 | Processor address |
| fc | input | 3 | Processor function code |
| strobe | input | 1 | Address strobe, active high |
| write | input | 1 | 1 = write cycle |
| jmp_vme | input | 1 | Jumper: boot from backplane memory |
| jmp_mezz | input | 1 | Jumper: boot from mezzanine interface |
| sel_flash | output | 1 | Boot select, on-board flash |
| sel_vme | output | 1 | Boot select, backplane memory |
| sel_mezz | output | 1 | Boot select, mezzanine interface |
| vme_am | output | 6 | Address modifier for backplane boot access |
| cpu_bus_sel | output | 1 | Access uses processor-side data bus |
| io_bus_sel | output | 1 | Access uses I/O-side data bus behind the sizer |
| cs_stage_en | output | 1 | Enable for the secondary chip-select stage |

## Verification
The assertions assume that inputs are stable and known for the whole time reset is released. They also assume that `addr`, `fc` and `write` have settled whenever `strobe` is high, because the selects follow those inputs combinationally. The bench changes every input only on the falling clock edge and returns the strobe to 0 between scenarios. It applies jumper changes only in ways that R9 covers: before a reset, or as a deliberate move in mid-run.

// File: rtl/boot_dec_pkg.sv
`timescale 1ns/1ps
package boot_dec_pkg;

  typedef enum logic [1:0] {
    SRC_FLASH = 2'd0,
    SRC_VME   = 2'd1,
    SRC_MEZZ  = 2'd2
  } boot_src_e;

  localparam logic [2:0] FC_SUP_PROG  = 3'd6;
  localparam logic [2:0] FC_CPU_SPACE = 3'd7;
  localparam logic [5:0] AM_SUP_PROG  = 6'h3E;
  localparam logic [5:0] AM_SUP_DATA  = 6'h3D;

  // Backplane jumper takes priority over mezzanine; neither means flash.
  function automatic boot_src_e pick_src(input logic jv, input logic jm);
    if (jv)      return SRC_VME;
    else if (jm) return SRC_MEZZ;
    else         return SRC_FLASH;
  endfunction

  // Address modifier from processor function code.
  function automatic logic [5:0] am_for_fc(input logic [2:0] f);
    return (f == FC_SUP_PROG) ? AM_SUP_PROG : AM_SUP_DATA;
  endfunction

endpackage

// File: rtl/boot_src_latch.sv
`timescale 1ns/1ps
module boot_src_latch
  import boot_dec_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      jmp_vme,
  input  logic      jmp_mezz,
  output boot_src_e src
);

  // Jumpers are loaded every cycle reset is held, frozen afterwards.
  always_ff @(posedge clk) begin
    if (!rst_n) src <= pick_src(jmp_vme, jmp_mezz);
  end

endmodule

// File: rtl/boot_phase_ctl.sv
`timescale 1ns/1ps
module boot_phase_ctl #(
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] EXIT_ADDR = 32'hFFFF_FFF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  output logic              boot_mode,
  output logic              exit_hit
);

  assign exit_hit = boot_mode && strobe && write && (addr == EXIT_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n)        boot_mode <= 1'b1;
    else if (exit_hit) boot_mode <= 1'b0;
  end

endmodule

// File: rtl/bus_predecode.sv
`timescale 1ns/1ps
module bus_predecode
  import boot_dec_pkg::*;
#(
  parameter int                HI_W     = 8,
  parameter int                IO_TAG_W = 4,
  parameter logic [IO_TAG_W-1:0] IO_TAG = 4'hF
) (
  input  logic            strobe,
  input  logic [HI_W-1:0] addr_hi,
  input  logic [2:0]      fc,
  input  logic            boot_mode,
  input  boot_src_e       src,
  output logic            redirect,
  output logic            sel_flash,
  output logic            sel_vme,
  output logic            sel_mezz,
  output logic [5:0]      vme_am,
  output logic            cpu_bus_sel,
  output logic            io_bus_sel
);

  logic cpu_space;
  logic low_range;
  logic io_win;
  logic live;

  assign cpu_space = (fc == FC_CPU_SPACE);
  assign low_range = (addr_hi == '0);
  assign io_win    = (addr_hi[HI_W-1 -: IO_TAG_W] == IO_TAG);
  assign live      = strobe && !cpu_space;
  assign redirect  = live && boot_mode && low_range;

  assign sel_flash = redirect && (src == SRC_FLASH);
  assign sel_vme   = redirect && (src == SRC_VME);
  assign sel_mezz  = redirect && (src == SRC_MEZZ);
  assign vme_am    = sel_vme ? am_for_fc(fc) : 6'h00;

  always_comb begin
    if (!live) begin
      io_bus_sel  = 1'b0;
      cpu_bus_sel = 1'b0;
    end else if (redirect) begin
      io_bus_sel  = (src == SRC_FLASH);
      cpu_bus_sel = (src != SRC_FLASH);
    end else begin
      io_bus_sel  = io_win;
      cpu_bus_sel = !io_win;
    end
  end

endmodule

// File: rtl/boot_redirect_decoder.sv
`timescale 1ns/1ps
module boot_redirect_decoder
  import boot_dec_pkg::*;
#(
  parameter int                  ADDR_W      = 32,
  parameter int                  BOOT_SPAN_W = 24,
  parameter int                  IO_TAG_W    = 4,
  parameter logic [IO_TAG_W-1:0] IO_TAG      = 4'hF,
  parameter logic [ADDR_W-1:0]   EXIT_ADDR   = 32'hFFFF_FFF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        fc,
  input  logic              strobe,
  input  logic              write,
  input  logic              jmp_vme,
  input  logic              jmp_mezz,
  output logic              sel_flash,
  output logic              sel_vme,
  output logic              sel_mezz,
  output logic [5:0]        vme_am,
  output logic              cpu_bus_sel,
  output logic              io_bus_sel,
  output logic              cs_stage_en
);

  localparam int HI_W = ADDR_W - BOOT_SPAN_W;

  boot_src_e src;
  logic      boot_mode;
  logic      exit_hit;
  logic      redirect;

  boot_src_latch u_src (
    .clk      (clk),
    .rst_n    (rst_n),
    .jmp_vme  (jmp_vme),
    .jmp_mezz (jmp_mezz),
    .src      (src)
  );

  boot_phase_ctl #(
    .ADDR_W    (ADDR_W),
    .EXIT_ADDR (EXIT_ADDR)
  ) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .write     (write),
    .addr      (addr),
    .boot_mode (boot_mode),
    .exit_hit  (exit_hit)
  );

  bus_predecode #(
    .HI_W     (HI_W),
    .IO_TAG_W (IO_TAG_W),
    .IO_TAG   (IO_TAG)
  ) u_dec (
    .strobe      (strobe),
    .addr_hi     (addr[ADDR_W-1:BOOT_SPAN_W]),
    .fc          (fc),
    .boot_mode   (boot_mode),
    .src         (src),
    .redirect    (redirect),
    .sel_flash   (sel_flash),
    .sel_vme     (sel_vme),
    .sel_mezz    (sel_mezz),
    .vme_am      (vme_am),
    .cpu_bus_sel (cpu_bus_sel),
    .io_bus_sel  (io_bus_sel)
  );

  assign cs_stage_en = !boot_mode;

endmodule

// File: rtl/boot_redirect_decoder_chk.sv
`timescale 1ns/1ps
module boot_redirect_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       strobe,
  input logic [2:0] fc,
  input logic       exit_hit,
  input logic       redirect,
  input logic       sel_flash,
  input logic       sel_vme,
  input logic       sel_mezz,
  input logic [5:0] vme_am,
  input logic       cpu_bus_sel,
  input logic       io_bus_sel,
  input logic       cs_stage_en
);

  // R6
  strobe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |-> !(sel_flash || sel_vme || sel_mezz || cpu_bus_sel || io_bus_sel));

  // R11
  one_boot_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_flash, sel_vme, sel_mezz}));

  // R11
  flash_on_io_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_flash |-> (io_bus_sel && !cpu_bus_sel));

  // R11
  redirect_has_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> $countones({sel_flash, sel_vme, sel_mezz}) == 1);

  // R5
  am_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_vme |-> (vme_am == ((fc == 3'd6) ? 6'h3E : 6'h3D)));

  // R5
  am_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_vme |-> (vme_am == 6'h00));

  // R7
  exit_handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exit_hit |=> cs_stage_en);

  // R7
  handover_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_stage_en |=> cs_stage_en);

  // R8
  no_boot_after_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_stage_en |-> !(sel_flash || sel_vme || sel_mezz));

  // R10
  bus_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_bus_sel && io_bus_sel));

  // R10
  cpu_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fc == 3'd7) |-> !(cpu_bus_sel || io_bus_sel));

endmodule

bind boot_redirect_decoder boot_redirect_decoder_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .strobe      (strobe),
  .fc          (fc),
  .exit_hit    (exit_hit),
  .redirect    (redirect),
  .sel_flash   (sel_flash),
  .sel_vme     (sel_vme),
  .sel_mezz    (sel_mezz),
  .vme_am      (vme_am),
  .cpu_bus_sel (cpu_bus_sel),
  .io_bus_sel  (io_bus_sel),
  .cs_stage_en (cs_stage_en)
);

// File: tb/test_boot_redirect_decoder.sv
`timescale 1ns/1ps
module test_boot_redirect_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] addr = '0;
  logic [2:0]  fc = 3'd5;
  logic        strobe = 1'b0;
  logic        write = 1'b0;
  logic        jmp_vme = 1'b0;
  logic        jmp_mezz = 1'b0;
  logic        sel_flash, sel_vme, sel_mezz;
  logic [5:0]  vme_am;
  logic        cpu_bus_sel, io_bus_sel, cs_stage_en;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [31:0] EXIT = 32'hFFFF_FFF0;

  always #4 clk = ~clk;

  boot_redirect_decoder i_boot_redirect_decoder (
    .clk(clk), .rst_n(rst_n), .addr(addr), .fc(fc), .strobe(strobe),
    .write(write), .jmp_vme(jmp_vme), .jmp_mezz(jmp_mezz),
    .sel_flash(sel_flash), .sel_vme(sel_vme), .sel_mezz(sel_mezz),
    .vme_am(vme_am), .cpu_bus_sel(cpu_bus_sel), .io_bus_sel(io_bus_sel),
    .cs_stage_en(cs_stage_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // {flash, vme, mezz}
  function automatic logic [31:0] bsel();
    return {29'd0, sel_flash, sel_vme, sel_mezz};
  endfunction

  // {cpu, io}
  function automatic logic [31:0] bus();
    return {30'd0, cpu_bus_sel, io_bus_sel};
  endfunction

  task automatic do_reset(input logic jv, input logic jm);
    @(negedge clk);
    strobe = 1'b0; write = 1'b0; jmp_vme = jv; jmp_mezz = jm; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic access(input logic [31:0] a, input logic [2:0] f, input logic w);
    @(negedge clk);
    addr = a; fc = f; write = w; strobe = 1'b1;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    strobe = 1'b0; write = 1'b0;
    #1;
  endtask

  task automatic t_reset_state();
    do_reset(1'b0, 1'b0);
    chk("R1 cs_stage_en after reset", {31'd0, cs_stage_en}, 32'd0);
    chk("R6 boot selects idle", bsel(), 32'd0);
    chk("R6 bus selects idle", bus(), 32'd0);
    chk("R5 am idle", {26'd0, vme_am}, 32'd0);
  endtask

  task automatic t_flash_default();
    do_reset(1'b0, 1'b0);
    access(32'h0000_0000, 3'd6, 1'b0);
    chk("R2 flash at base", bsel(), 32'd4);
    chk("R11 flash uses io bus", bus(), 32'd1);
    access(32'h00FF_FFFF, 3'd5, 1'b0);
    chk("R4 top of boot range", bsel(), 32'd4);
    access(32'h0100_0000, 3'd5, 1'b0);
    chk("R4 just above range", bsel(), 32'd0);
    chk("R10 normal cpu bus", bus(), 32'd2);
    access(32'hF000_0100, 3'd5, 1'b0);
    chk("R10 io window", bus(), 32'd1);
    access(32'h0000_0040, 3'd7, 1'b0);
    chk("R10 cpu space no bus", bus(), 32'd0);
    chk("R10 cpu space no boot sel", bsel(), 32'd0);
    idle();
    chk("R6 strobe low", bsel() | bus(), 32'd0);
    chk("R1 still booting", {31'd0, cs_stage_en}, 32'd0);
  endtask

  task automatic t_vme_source();
    do_reset(1'b1, 1'b0);
    access(32'h0000_0010, 3'd6, 1'b0);
    chk("R3 vme select", bsel(), 32'd2);
    chk("R5 am sup prog", {26'd0, vme_am}, 32'h3E);
    chk("R11 vme uses cpu bus", bus(), 32'd2);
    access(32'h0012_3456, 3'd5, 1'b0);
    chk("R5 am sup data", {26'd0, vme_am}, 32'h3D);
    access(32'h0200_0000, 3'd5, 1'b0);
    chk("R5 am zero outside range", {26'd0, vme_am}, 32'd0);
    idle();
    do_reset(1'b1, 1'b1);
    access(32'h0000_0000, 3'd5, 1'b0);
    chk("R3 both jumpers give vme", bsel(), 32'd2);
    idle();
  endtask

  task automatic t_mezz_source();
    do_reset(1'b0, 1'b1);
    access(32'h0080_0000, 3'd6, 1'b0);
    chk("R3 mezz select", bsel(), 32'd1);
    chk("R5 am zero for mezz", {26'd0, vme_am}, 32'd0);
    chk("R11 mezz uses cpu bus", bus(), 32'd2);
    idle();
  endtask

  task automatic t_jumper_static();
    do_reset(1'b0, 1'b0);
    @(negedge clk);
    jmp_vme = 1'b1;
    repeat (3) @(negedge clk);
    access(32'h0000_0100, 3'd5, 1'b0);
    chk("R9 jumper move ignored", bsel(), 32'd4);
    idle();
    do_reset(1'b1, 1'b0);
    access(32'h0000_0100, 3'd5, 1'b0);
    chk("R9 jumper taken at reset", bsel(), 32'd2);
    idle();
  endtask

  task automatic t_boot_exit();
    do_reset(1'b0, 1'b0);
    access(EXIT, 3'd5, 1'b0);
    idle();
    chk("R7 read does not exit", {31'd0, cs_stage_en}, 32'd0);
    access(EXIT, 3'd5, 1'b1);
    chk("R7 not before edge", {31'd0, cs_stage_en}, 32'd0);
    idle();
    chk("R7 handover after write", {31'd0, cs_stage_en}, 32'd1);
    access(32'h0000_0000, 3'd6, 1'b0);
    chk("R8 no boot sel after exit", bsel(), 32'd0);
    chk("R8 low range on cpu bus", bus(), 32'd2);
    repeat (4) @(negedge clk);
    chk("R7 handover sticky", {31'd0, cs_stage_en}, 32'd1);
    idle();
    do_reset(1'b0, 1'b0);
    chk("R1 reset re-enters boot", {31'd0, cs_stage_en}, 32'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #800000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset_state();
    t_flash_default();
    t_vme_source();
    t_mezz_source();
    t_jumper_static();
    t_boot_exit();
    finish_run();
  end

endmodule